// File: doc/BRIEF.md
# Framed Synchronous Serial Port with Byte/Word Transfers

This block is a codec-style serial port. A transmit half and a receive half each run on their own external bit clock and take their own external frame-sync input. Software reaches the port through two data locations on a simple register bus: a transmit data register that it writes and a receive data register that it reads. A single format input selects 8-bit or 16-bit transfers for both halves.

A frame-sync pulse starts each transfer, and bits travel most significant first. The transmit half moves the pending transmit word into its shifter at frame sync. It signals that move with a one-cycle transmit interrupt in the system clock domain. It drives its serial output only while a frame is being shifted and releases the line otherwise, so several ports can share one wire with one talker and many listeners. The receive half collects a frame on the falling edges of its clock and hands the result to the system domain, where it appears in the receive data register together with a one-cycle receive interrupt. All handoffs between clock domains go through two-flop synchronizers.

Top module: `ser_frame_port`

## Requirements
- R1: Bus address 0 selects the transmit data register: a write stores `bus_wdata` and a read returns the last value written. Address 1 selects the receive data register, which is read-only, and writes to it are ignored. `bus_rdata` shows the register at `bus_addr` combinationally, and both registers read 0 after reset.
- R2: With `fmt_word`=1 a frame carries 16 bits, bit 15 of the transmit register first and bit 0 last.
- R3: When `tx_fsync` is high at a rising edge of `tx_bclk` and a word is pending, the first bit is driven from that edge on. Each following rising edge advances one bit. `tx_drive` is high for exactly the frame length in bit clocks and low before and after.
- R4: With `fmt_word`=0 a transmit frame carries 8 bits, bits 7 down to 0 of the transmit register.
- R5: `tx_irq` is a single system-clock pulse that follows each move of the transmit register into the shifter. It is low after reset.
- R6: A frame sync that arrives while no written word is pending starts nothing: `tx_drive` stays low and no `tx_irq` pulse follows.
- R7: `rx_fsync` high at a falling edge of `rx_bclk` arms the receiver. The next N falling edges (N = 16 in word mode) sample `rx_din` MSB first. The resulting word then appears in the receive register, and at the same moment `rx_irq` pulses for one system cycle.
- R8: With `fmt_word`=0 a receive frame takes 8 bits, and the receive register holds them in bits 7..0 with bits 15..8 zero.
- R9: Activity on `rx_din` without a frame sync is ignored: no `rx_irq` pulse and the receive register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the register bus and interrupts |
| rst_n | input | 1 | Asynchronous active-low reset for all three domains |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = transmit register, 1 = receive register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| fmt_word | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| tx_bclk | input | 1 | External transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync, sampled on rising `tx_bclk` |
| tx_dout | output | 1 | Serial transmit data |
| tx_drive | output | 1 | Output enable for `tx_dout`; low means the line is released |
| tx_irq | output | 1 | Transmit register taken by the shifter |
| rx_bclk | input | 1 | External receive bit clock |
| rx_fsync | input | 1 | Receive frame sync, sampled on falling `rx_bclk` |
| rx_din | input | 1 | Serial receive data |
| rx_irq | output | 1 | New word in the receive register |

## Verification
If the bit counter or the format setting inside a half goes wrong, the frame at the serial pins has the wrong length. That shows within one frame as `tx_drive` held for too many or too few bit clocks, or as a received value shifted by the missing bits. If a handshake toggle between domains goes wrong, an interrupt goes missing or repeats, a transmit frame starts with no data pending, or a stale word is reloaded. These are visible within a few system cycles of the frame sync or frame end, because every frame is matched against a queued expected word. If the receive zero extension fails, upper bits left over from the previous word show up in the register as soon as the next byte frame completes.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // Default data path width and short-frame width.
  localparam int unsigned SFP_DW = 16;
  localparam int unsigned SFP_BW = 8;

  // Register bus address decode.
  typedef enum logic {
    SFP_SEL_TX = 1'b0,
    SFP_SEL_RX = 1'b1
  } sfp_sel_e;

endpackage

// File: rtl/sfp_sync_bit.sv
// Multi-stage synchronizer. With d tied high it also serves as a reset
// release synchronizer (asynchronous assert, synchronous release).
module sfp_sync_bit #(
  parameter int unsigned STAGES  = 2,
  parameter bit          FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sfp_tx_half.sv
// Transmit half: register and interrupt in the system domain, shifter in
// the transmit bit clock domain, toggle handshake between them.
module sfp_tx_half #(
  parameter int unsigned DW     = 16,
  parameter int unsigned BW     = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] buf_o,
  output logic          irq_o,
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          word_b,
  input  logic          fsync,
  output logic          dout,
  output logic          drive
);

  localparam int unsigned   CW     = $clog2(DW);
  localparam logic [CW-1:0] LAST_W = CW'(DW - 1);
  localparam logic [CW-1:0] LAST_B = CW'(BW - 1);

  // ---------------- system domain ----------------
  logic [DW-1:0] buf_q, buf_d;
  logic          req_q, req_d;
  logic          ack_s;
  logic          ack_seen_q, ack_seen_d;
  logic          irq_q, irq_d;
  logic          ack_q, ack_d;

  always_comb begin
    buf_d      = buf_q;
    req_d      = req_q;
    if (wr_en) begin
      buf_d = wdata;
      req_d = ~req_q;
    end
    ack_seen_d = ack_s;
    irq_d      = ack_s ^ ack_seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q      <= '0;
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      buf_q      <= buf_d;
      req_q      <= req_d;
      ack_seen_q <= ack_seen_d;
      irq_q      <= irq_d;
    end
  end

  sfp_sync_bit #(.STAGES(SYNC_N), .FALLING(1'b0)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_q),
    .q     (ack_s)
  );

  assign buf_o = buf_q;
  assign irq_o = irq_q;

  // ---------------- bit clock domain ----------------
  logic          req_s;
  logic          pend;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  sfp_sync_bit #(.STAGES(SYNC_N), .FALLING(1'b0)) u_req_sync (
    .clk   (bclk),
    .rst_n (brst_n),
    .d     (req_q),
    .q     (req_s)
  );

  assign pend = req_s ^ ack_q;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    ack_d = ack_q;
    if (fsync && pend) begin
      sh_d  = word_b ? buf_q : {buf_q[BW-1:0], {(DW-BW){1'b0}}};
      cnt_d = word_b ? LAST_W : LAST_B;
      act_d = 1'b1;
      ack_d = ~ack_q;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        act_d = 1'b0;
      end else begin
        sh_d  = {sh_q[DW-2:0], 1'b0};
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
      ack_q <= ack_d;
    end
  end

  assign dout  = sh_q[DW-1];
  assign drive = act_q;

endmodule

// File: rtl/sfp_rx_half.sv
// Receive half: shifter on falling receive bit clock, toggle handoff of the
// completed word into the system domain.
module sfp_rx_half #(
  parameter int unsigned DW     = 16,
  parameter int unsigned BW     = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] data_o,
  output logic          irq_o,
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          word_b,
  input  logic          fsync,
  input  logic          din
);

  localparam int unsigned   CW     = $clog2(DW);
  localparam logic [CW-1:0] LAST_W = CW'(DW - 1);
  localparam logic [CW-1:0] LAST_B = CW'(BW - 1);

  // ---------------- bit clock domain (falling edge) ----------------
  logic [DW-1:0] sh_q, sh_d;
  logic [DW-1:0] sh_next;
  logic [DW-1:0] hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          tgl_q, tgl_d;

  assign sh_next = {sh_q[DW-2:0], din};

  always_comb begin
    sh_d   = sh_q;
    hold_d = hold_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    tgl_d  = tgl_q;
    if (act_q) begin
      sh_d = sh_next;
      if (cnt_q == '0) begin
        act_d  = 1'b0;
        hold_d = word_b ? sh_next : {{(DW-BW){1'b0}}, sh_next[BW-1:0]};
        tgl_d  = ~tgl_q;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
    if (fsync) begin
      act_d = 1'b1;
      cnt_d = word_b ? LAST_W : LAST_B;
    end
  end

  always_ff @(negedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      tgl_q  <= tgl_d;
    end
  end

  // ---------------- system domain ----------------
  logic          tgl_s;
  logic          seen_q, seen_d;
  logic [DW-1:0] data_q, data_d;
  logic          irq_q, irq_d;
  logic          fresh;

  sfp_sync_bit #(.STAGES(SYNC_N), .FALLING(1'b0)) u_tgl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (tgl_q),
    .q     (tgl_s)
  );

  assign fresh = tgl_s ^ seen_q;

  always_comb begin
    seen_d = tgl_s;
    irq_d  = fresh;
    data_d = fresh ? hold_q : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      data_q <= data_d;
      irq_q  <= irq_d;
    end
  end

  assign data_o = data_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/ser_frame_port.sv
module ser_frame_port #(
  parameter int unsigned DW     = sfp_pkg::SFP_DW,
  parameter int unsigned BW     = sfp_pkg::SFP_BW,
  parameter int unsigned SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          fmt_word,
  input  logic          tx_bclk,
  input  logic          tx_fsync,
  output logic          tx_dout,
  output logic          tx_drive,
  output logic          tx_irq,
  input  logic          rx_bclk,
  input  logic          rx_fsync,
  input  logic          rx_din,
  output logic          rx_irq
);

  logic              sys_rst_n;
  logic              tx_rst_n;
  logic              rx_rst_n;
  logic              tx_word;
  logic              rx_word;
  sfp_pkg::sfp_sel_e addr_sel;
  logic              tx_wr;
  logic [DW-1:0]     tx_reg_q;
  logic [DW-1:0]     rx_reg_q;

  // Reset release per clock domain.
  sfp_sync_bit #(.STAGES(SYNC_N), .FALLING(1'b0)) u_sys_rst (
    .clk (clk), .rst_n (rst_n), .d (1'b1), .q (sys_rst_n)
  );
  sfp_sync_bit #(.STAGES(SYNC_N), .FALLING(1'b0)) u_tx_rst (
    .clk (tx_bclk), .rst_n (rst_n), .d (1'b1), .q (tx_rst_n)
  );
  sfp_sync_bit #(.STAGES(SYNC_N), .FALLING(1'b1)) u_rx_rst (
    .clk (rx_bclk), .rst_n (rst_n), .d (1'b1), .q (rx_rst_n)
  );

  // Format bit brought into each bit clock domain.
  sfp_sync_bit #(.STAGES(SYNC_N), .FALLING(1'b0)) u_tx_fmt (
    .clk (tx_bclk), .rst_n (tx_rst_n), .d (fmt_word), .q (tx_word)
  );
  sfp_sync_bit #(.STAGES(SYNC_N), .FALLING(1'b1)) u_rx_fmt (
    .clk (rx_bclk), .rst_n (rx_rst_n), .d (fmt_word), .q (rx_word)
  );

  // Register bus decode.
  assign addr_sel = sfp_pkg::sfp_sel_e'(bus_addr);
  assign tx_wr    = bus_sel && bus_wr && (addr_sel == sfp_pkg::SFP_SEL_TX);

  always_comb begin
    case (addr_sel)
      sfp_pkg::SFP_SEL_TX: bus_rdata = tx_reg_q;
      default:             bus_rdata = rx_reg_q;
    endcase
  end

  sfp_tx_half #(.DW(DW), .BW(BW), .SYNC_N(SYNC_N)) u_tx (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .wr_en  (tx_wr),
    .wdata  (bus_wdata),
    .buf_o  (tx_reg_q),
    .irq_o  (tx_irq),
    .bclk   (tx_bclk),
    .brst_n (tx_rst_n),
    .word_b (tx_word),
    .fsync  (tx_fsync),
    .dout   (tx_dout),
    .drive  (tx_drive)
  );

  sfp_rx_half #(.DW(DW), .BW(BW), .SYNC_N(SYNC_N)) u_rx (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .data_o (rx_reg_q),
    .irq_o  (rx_irq),
    .bclk   (rx_bclk),
    .brst_n (rx_rst_n),
    .word_b (rx_word),
    .fsync  (rx_fsync),
    .din    (rx_din)
  );

endmodule

// File: rtl/ser_frame_port_chk.sv
module ser_frame_port_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic          bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          fmt_word,
  input logic          tx_bclk,
  input logic          tx_fsync,
  input logic          tx_drive,
  input logic          tx_irq,
  input logic          rx_irq,
  input logic [DW-1:0] rx_reg
);

  // Age of the current format setting in system cycles (saturating).
  logic       fmt_prev_q;
  logic [6:0] fmt_age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_prev_q <= 1'b0;
      fmt_age_q  <= '0;
    end else begin
      fmt_prev_q <= fmt_word;
      if (fmt_word != fmt_prev_q)  fmt_age_q <= '0;
      else if (fmt_age_q != 7'd100) fmt_age_q <= fmt_age_q + 7'd1;
    end
  end

  // R1: a read of the transmit register right after a write returns it.
  p_txreg_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_addr && $past(bus_sel && bus_wr && !bus_addr))
      |-> (bus_rdata == $past(bus_wdata)));

  // R3: the line is only taken after a sampled frame sync.
  p_drive_after_sync_r3: assert property (@(posedge tx_bclk) disable iff (!rst_n)
    $rose(tx_drive) |-> $past(tx_fsync));

  // R5: transmit interrupt lasts one system cycle.
  p_tx_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  // R7: receive interrupt lasts one system cycle.
  p_rx_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R8: a byte frame under a settled byte format leaves the upper bits zero.
  p_rx_zero_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !fmt_word && (fmt_age_q == 7'd100)) |-> (rx_reg[DW-1:BW] == '0));

endmodule

bind ser_frame_port ser_frame_port_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .fmt_word  (fmt_word),
  .tx_bclk   (tx_bclk),
  .tx_fsync  (tx_fsync),
  .tx_drive  (tx_drive),
  .tx_irq    (tx_irq),
  .rx_irq    (rx_irq),
  .rx_reg    (rx_reg_q)
);

// File: tb/ser_frame_port_tb.sv
`timescale 1ns/1ps
module ser_frame_port_tb;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr, bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        fmt_word;
  logic        tx_bclk, tx_fsync, tx_dout, tx_drive, tx_irq;
  logic        rx_bclk, rx_fsync, rx_din, rx_irq;

  int total = 0;
  int bad = 0;
  int tx_irq_cnt = 0;
  int rx_irq_cnt = 0;
  int rx_sent = 0;
  logic [15:0] tx_exp_q[$];
  string       tx_tag_q[$];
  logic [15:0] rx_exp_q[$];
  string       rx_tag_q[$];

  ser_frame_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fmt_word(fmt_word),
    .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .tx_dout(tx_dout),
    .tx_drive(tx_drive), .tx_irq(tx_irq),
    .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_din(rx_din), .rx_irq(rx_irq)
  );

  initial begin clk = 1'b0;     forever #2  clk = ~clk; end
  initial begin tx_bclk = 1'b0; forever #20 tx_bclk = ~tx_bclk; end
  initial begin rx_bclk = 1'b0; forever #28 rx_bclk = ~rx_bclk; end

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Interrupt counting and receive scoreboard monitor.
  always @(negedge clk) begin
    if (tx_irq === 1'b1) tx_irq_cnt++;
    if (rx_irq === 1'b1) begin
      rx_irq_cnt++;
      if (rx_exp_q.size() == 0) begin
        check("R9", "unexpected rx_irq", 16'd1, 16'd0);
      end else begin
        check(rx_tag_q.pop_front(), "rx word", bus_rdata, rx_exp_q.pop_front());
      end
    end
  end

  // Transmit scoreboard monitor: samples mid-bit on falling tx_bclk.
  initial begin : tx_mon
    logic [15:0] acc;
    int n;
    acc = '0;
    n = 0;
    forever begin
      @(negedge tx_bclk);
      if (tx_drive === 1'b1) begin
        acc = {acc[14:0], tx_dout};
        n++;
        if (n == (fmt_word ? 16 : 8)) begin
          if (tx_exp_q.size() == 0) check("R6", "unexpected tx frame", 16'd1, 16'd0);
          else check(tx_tag_q.pop_front(), "tx frame", acc, tx_exp_q.pop_front());
          acc = '0;
          n = 0;
        end
      end
    end
  end

  task automatic bus_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 1'b0) begin
      tx_exp_q.push_back(fmt_word ? d : {8'h00, d[7:0]});
      tx_tag_q.push_back(fmt_word ? "R2" : "R4");
    end
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b1;
  endtask

  task automatic bus_read_tx(input logic [15:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0;
    #1 check("R1", "tx register readback", bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0; bus_addr = 1'b1;
  endtask

  // One frame sync on the transmit side; counts bit periods with drive high.
  task automatic tx_frame(input bit expect_data, input string req);
    int len;
    int cnt;
    len = fmt_word ? 16 : 8;
    cnt = 0;
    @(negedge tx_bclk); tx_fsync = 1'b1;
    @(negedge tx_bclk); tx_fsync = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (tx_drive === 1'b1) cnt++;
      @(negedge tx_bclk);
    end
    check(req, "drive bit periods", 16'(cnt), expect_data ? 16'(len) : 16'd0);
    check(req, "drive low after frame", {15'd0, tx_drive}, 16'd0);
  endtask

  task automatic rx_send(input logic [15:0] w);
    int len;
    len = fmt_word ? 16 : 8;
    rx_exp_q.push_back(fmt_word ? w : {8'h00, w[7:0]});
    rx_tag_q.push_back(fmt_word ? "R7" : "R8");
    rx_sent++;
    @(posedge rx_bclk); #1 rx_fsync = 1'b1;
    @(posedge rx_bclk); #1 rx_fsync = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_din = w[len-1-i];
      @(posedge rx_bclk); #1;
    end
    rx_din = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin : watchdog
    #600000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    int irq0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b1;
    bus_wdata = '0; fmt_word = 1'b1;
    tx_fsync = 1'b0; rx_fsync = 1'b0; rx_din = 1'b0;
    #200;
    @(negedge clk) rst_n = 1'b1;
    #400;

    // Reset state
    @(negedge clk);
    check("R1", "rx register after reset", bus_rdata, 16'h0000);
    check("R3", "tx_drive after reset", {15'd0, tx_drive}, 16'd0);
    check("R5", "tx_irq after reset", {15'd0, tx_irq}, 16'd0);
    check("R7", "rx_irq after reset", {15'd0, rx_irq}, 16'd0);
    bus_read_tx(16'h0000);

    // Word transmit frames
    bus_write(1'b0, 16'hA5C3);
    bus_read_tx(16'hA5C3);
    repeat (40) @(negedge clk);
    tx_frame(1'b1, "R3");
    check("R5", "tx_irq count after frame 1", 16'(tx_irq_cnt), 16'd1);

    bus_write(1'b0, 16'h8001);
    repeat (40) @(negedge clk);
    tx_frame(1'b1, "R3");
    check("R5", "tx_irq count after frame 2", 16'(tx_irq_cnt), 16'd2);

    // Underrun: frame sync with nothing pending
    irq0 = tx_irq_cnt;
    tx_frame(1'b0, "R6");
    repeat (20) @(negedge clk);
    check("R6", "no tx_irq on underrun", 16'(tx_irq_cnt), 16'(irq0));

    // Byte transmit frame
    fmt_word = 1'b0;
    repeat (120) @(negedge clk);
    bus_write(1'b0, 16'h3C96);
    repeat (40) @(negedge clk);
    tx_frame(1'b1, "R4");
    check("R5", "tx_irq count after byte frame", 16'(tx_irq_cnt), 16'd3);

    // Word receive frames
    fmt_word = 1'b1;
    repeat (120) @(negedge clk);
    rx_send(16'hC35A);
    rx_send(16'h0001);
    rx_send(16'hB7E5);

    // Byte receive with upper shifter bits left nonzero
    fmt_word = 1'b0;
    repeat (120) @(negedge clk);
    rx_send(16'hFF6B);

    // Writes to the receive register are ignored
    bus_write(1'b1, 16'hFFFF);
    @(negedge clk);
    check("R1", "rx register after write attempt", bus_rdata, 16'h006B);

    // Serial activity without frame sync is ignored
    irq0 = rx_irq_cnt;
    for (int i = 0; i < 24; i++) begin
      @(posedge rx_bclk); #1 rx_din = ~rx_din;
    end
    rx_din = 1'b0;
    repeat (40) @(negedge clk);
    check("R9", "no rx_irq without sync", 16'(rx_irq_cnt), 16'(irq0));
    check("R9", "rx register unchanged", bus_rdata, 16'h006B);

    // Scoreboards drained
    check("R7", "rx frames delivered", 16'(rx_irq_cnt), 16'(rx_sent));
    check("R2", "tx expected queue empty", 16'(tx_exp_q.size()), 16'd0);
    check("R7", "rx expected queue empty", 16'(rx_exp_q.size()), 16'd0);

    summary();
    $finish;
  end

endmodule